// File: doc/BRIEF.md
# Electronic Shutter Exposure Controller

This block drives the substrate clear pulse of a CCD, which empties the photosites and so sets the exposure time. It also produces a mask that blocks the sensor-gate transfer pulses. In every field it counts lines from the sensor-gate line onward. It can hold off a programmed number of lines, then emits one clear pulse per line for a programmed number of lines. In a high-precision variant the last of those lines carries one extra pulse at a fine position.

A software trigger starts a multi-field sequence at the next field start. During the exposure part both the clear pulse and the sensor-gate transfer are blocked for a programmed number of fields. A readout part follows, in which only the clear pulse is held off for a further programmed number of fields. A readout can also be started alone. The pixel and line counts, the line-start strobe and the field-start strobe come from the surrounding timing core.

Top module: `shut_expo_ctrl`

## Requirements
- R1: In each field the line sequencer loads on the line-start strobe whose line count equals `gate_line`+1. From there, after the hold-off lines, clear pulses appear on exactly `clr_count` consecutive lines. A field-start strobe that is not itself that line ends any remaining pulse lines.
- R2: On a clear line, `sub_clr` equals the latched polarity XOR (pixel >= on position AND pixel < off position). The output is registered, so it shows the value for pixel count p in the cycle after p is presented. On all other lines `sub_clr` rests at the latched polarity.
- R3: `clr_hold` = h makes the first h lines after the sensor-gate line carry no clear pulse. The pulse lines then start on line `gate_line`+1+h.
- R4: Polarity, on/off positions, fine position, count and hold-off are sampled only at the line start of line `gate_line`+1. Changes at any other time do not alter the waveform until the next such line.
- R5: The last clear line also carries an extra pulse from `clr_fine_pos` for FINE_W (default 4) pixels. A fine position of all ones disables it, and the latched fine position resets to all ones.
- R6: With `trig_wr` and `trig_exp` high, at the next field start with `exp_fields` > 0 the block enters exposure. For `exp_fields` fields it holds `sub_clr` at its resting level and drives `gate_block` high.
- R7: When exposure ends, readout follows for `rd_fields` fields with `sub_clr` at rest and `gate_block` low. If `rd_fields` is 0 the block returns to normal at once.
- R8: An exposure trigger with `exp_fields` = 0 gives no exposure fields. Clear pulses stay as in normal operation and only the readout part, if any, runs.
- R9: `trig_wr` with only `trig_rd` high starts readout alone at the next field start, for `rd_fields` fields with `gate_block` low.
- R10: Triggers written while a sequence runs, or in the cycle in which one starts, are dropped. A trigger written in a field-start cycle that starts nothing waits for the next field start. Trigger bits clear when taken. `seq_busy` is high from the cycle after the accepting field start until the cycle after the last readout field ends.
- R11: During and after reset, `sub_clr`, `gate_block` and `seq_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vd | input | 1 | Field-start strobe (coincides with a line start) |
| hd | input | 1 | Line-start strobe, high in the cycle where pixel count is 0 |
| pix_cnt | input | PIX_W | Pixel position in the line |
| line_cnt | input | LINE_W | Line index in the field, already updated on `hd` |
| gate_line | input | LINE_W | Sensor-gate active line |
| clr_pol | input | 1 | Clear pulse resting polarity |
| clr_tog_on | input | PIX_W | Pixel where the clear pulse starts |
| clr_tog_off | input | PIX_W | Pixel where the clear pulse ends (exclusive) |
| clr_fine_pos | input | PIX_W | Extra last-line pulse position, all ones = off |
| clr_count | input | NUM_W | Clear pulse lines per field |
| clr_hold | input | HOLD_W | Lines held off after the sensor-gate line |
| exp_fields | input | EXP_W | Exposure field count |
| rd_fields | input | RD_W | Readout field count |
| trig_wr | input | 1 | Trigger write strobe |
| trig_exp | input | 1 | Exposure trigger bit |
| trig_rd | input | 1 | Readout trigger bit |
| sub_clr | output | 1 | Substrate clear pulse |
| gate_block | output | 1 | High while sensor-gate pulses must be blocked |
| seq_busy | output | 1 | Exposure/readout sequence in progress |

## Verification
The hardest case to reach is a configuration change in the middle of a field, after the sensor-gate line has already latched the settings. The stimulus waits for a field start, lets four lines go by and only then widens the pulse. A waveform that changes before the next field shows a latching fault. Trigger timing is also delicate. One trigger is placed in the exact field-start cycle, and another is written while a sequence is already running. The first must wait one field and the second must vanish.

// File: rtl/shut_pkg.sv
package shut_pkg;
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_EXPO = 2'd1,
      FS_READ = 2'd2
   } fld_state_e;
endpackage

// File: rtl/shut_line_seq.sv
module shut_line_seq #(
   parameter int PIX_W  = 13,
   parameter int LINE_W = 12,
   parameter int NUM_W  = 12,
   parameter int HOLD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vd,
   input  logic              hd,
   input  logic [LINE_W-1:0] line_cnt,
   input  logic [LINE_W-1:0] gate_line,
   input  logic              cfg_pol,
   input  logic [PIX_W-1:0]  cfg_on,
   input  logic [PIX_W-1:0]  cfg_off,
   input  logic [PIX_W-1:0]  cfg_fine,
   input  logic [NUM_W-1:0]  cfg_num,
   input  logic [HOLD_W-1:0] cfg_hold,
   output logic              v_pol,
   output logic [PIX_W-1:0]  v_on,
   output logic [PIX_W-1:0]  v_off,
   output logic [PIX_W-1:0]  v_fine,
   output logic              line_on,
   output logic              line_last
);
   localparam logic [LINE_W-1:0] ONE_L = LINE_W'(1);
   localparam logic [NUM_W-1:0]  ONE_N = NUM_W'(1);

   logic              pol_q, pol_n;
   logic [PIX_W-1:0]  on_q, on_n, off_q, off_n, fine_q, fine_n;
   logic [HOLD_W-1:0] hold_q, hold_n;
   logic [NUM_W-1:0]  left_q, left_n;
   logic              first_line;

   assign first_line = hd && (line_cnt == gate_line + ONE_L);

   always_comb begin
      pol_n  = pol_q;
      on_n   = on_q;
      off_n  = off_q;
      fine_n = fine_q;
      hold_n = hold_q;
      left_n = left_q;
      if (first_line) begin
         pol_n  = cfg_pol;
         on_n   = cfg_on;
         off_n  = cfg_off;
         fine_n = cfg_fine;
         hold_n = cfg_hold;
         left_n = cfg_num;
      end else if (vd) begin
         hold_n = '0;
         left_n = '0;
      end else if (hd) begin
         if (hold_q != '0)      hold_n = hold_q - 1'b1;
         else if (left_q != '0) left_n = left_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pol_q  <= 1'b0;
         on_q   <= '0;
         off_q  <= '0;
         fine_q <= '1;
         hold_q <= '0;
         left_q <= '0;
      end else begin
         pol_q  <= pol_n;
         on_q   <= on_n;
         off_q  <= off_n;
         fine_q <= fine_n;
         hold_q <= hold_n;
         left_q <= left_n;
      end
   end

   assign v_pol     = pol_n;
   assign v_on      = on_n;
   assign v_off     = off_n;
   assign v_fine    = fine_n;
   assign line_on   = (hold_n == '0) && (left_n != '0);
   assign line_last = line_on && (left_n == ONE_N);

   AST_LINE_COUNT_ON_HD: assert property (@(posedge clk) disable iff (!rst_n)
      (left_q != $past(left_q)) |-> $past(hd)); // R1
   AST_HOLD_BEFORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q != '0) && !hd |=> (hold_q != '0) || (left_q == $past(left_q))); // R3
endmodule

// File: rtl/shut_pulse_gen.sv
module shut_pulse_gen #(
   parameter int PIX_W  = 13,
   parameter int FINE_W = 4,
   parameter bit HP_EN  = 1'b1
) (
   input  logic [PIX_W-1:0] pix_cnt,
   input  logic [PIX_W-1:0] on_pos,
   input  logic [PIX_W-1:0] off_pos,
   input  logic [PIX_W-1:0] fine_pos,
   input  logic             line_on,
   input  logic             line_last,
   output logic             pulse
);
   localparam int EXT_W = PIX_W + 1;

   logic in_main, in_fine;

   assign in_main = (pix_cnt >= on_pos) && (pix_cnt < off_pos);

   generate
      if (HP_EN) begin : g_fine
         logic [EXT_W-1:0] fine_end;
         logic             fine_off;
         assign fine_end = {1'b0, fine_pos} + EXT_W'(FINE_W);
         assign fine_off = &fine_pos;
         assign in_fine  = line_last && !fine_off && (pix_cnt >= fine_pos)
                           && ({1'b0, pix_cnt} < fine_end);
      end else begin : g_no_fine
         assign in_fine = 1'b0;
      end
   endgenerate

   assign pulse = line_on && (in_main || in_fine);
endmodule

// File: rtl/shut_field_fsm.sv
module shut_field_fsm
   import shut_pkg::*;
#(
   parameter int EXP_W = 12,
   parameter int RD_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vd,
   input  logic             trig_wr,
   input  logic             trig_exp,
   input  logic             trig_rd,
   input  logic [EXP_W-1:0] exp_fields,
   input  logic [RD_W-1:0]  rd_fields,
   output fld_state_e       st_n,
   output fld_state_e       st_q
);
   localparam int CNT_W = EXP_W;
   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

   logic             pe_q, pe_n, pr_q, pr_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;

   always_comb begin
      st_n  = st_q;
      cnt_n = cnt_q;
      pe_n  = pe_q;
      pr_n  = pr_q;
      if (vd) begin
         pe_n = 1'b0;
         pr_n = 1'b0;
         unique case (st_q)
            FS_IDLE: begin
               if (pe_q && (exp_fields != '0)) begin
                  st_n  = FS_EXPO;
                  cnt_n = exp_fields;
               end else if ((pe_q || pr_q) && (rd_fields != '0)) begin
                  st_n  = FS_READ;
                  cnt_n = CNT_W'(rd_fields);
               end
            end
            FS_EXPO: begin
               if (cnt_q == ONE_C) begin
                  if (rd_fields != '0) begin
                     st_n  = FS_READ;
                     cnt_n = CNT_W'(rd_fields);
                  end else begin
                     st_n  = FS_IDLE;
                     cnt_n = '0;
                  end
               end else begin
                  cnt_n = cnt_q - 1'b1;
               end
            end
            FS_READ: begin
               if (cnt_q == ONE_C) begin
                  st_n  = FS_IDLE;
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt_q - 1'b1;
               end
            end
            default: begin
               st_n  = FS_IDLE;
               cnt_n = '0;
            end
         endcase
      end
      if (trig_wr && (st_q == FS_IDLE) && (st_n == FS_IDLE)) begin
         pe_n = pe_n | trig_exp;
         pr_n = pr_n | trig_rd;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= FS_IDLE;
         cnt_q <= '0;
         pe_q  <= 1'b0;
         pr_q  <= 1'b0;
      end else begin
         st_q  <= st_n;
         cnt_q <= cnt_n;
         pe_q  <= pe_n;
         pr_q  <= pr_n;
      end
   end

   AST_NO_PEND_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != FS_IDLE) |-> !(pe_q || pr_q)); // R10
   AST_STATE_MOVES_ON_VD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != $past(st_q)) |-> $past(vd)); // R6
endmodule

// File: rtl/shut_expo_ctrl.sv
module shut_expo_ctrl
   import shut_pkg::*;
#(
   parameter int PIX_W  = 13,
   parameter int LINE_W = 12,
   parameter int NUM_W  = 12,
   parameter int HOLD_W = 4,
   parameter int EXP_W  = 12,
   parameter int RD_W   = 3,
   parameter int FINE_W = 4,
   parameter bit HP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vd,
   input  logic              hd,
   input  logic [PIX_W-1:0]  pix_cnt,
   input  logic [LINE_W-1:0] line_cnt,
   input  logic [LINE_W-1:0] gate_line,
   input  logic              clr_pol,
   input  logic [PIX_W-1:0]  clr_tog_on,
   input  logic [PIX_W-1:0]  clr_tog_off,
   input  logic [PIX_W-1:0]  clr_fine_pos,
   input  logic [NUM_W-1:0]  clr_count,
   input  logic [HOLD_W-1:0] clr_hold,
   input  logic [EXP_W-1:0]  exp_fields,
   input  logic [RD_W-1:0]   rd_fields,
   input  logic              trig_wr,
   input  logic              trig_exp,
   input  logic              trig_rd,
   output logic              sub_clr,
   output logic              gate_block,
   output logic              seq_busy
);
   if (PIX_W < 2)        begin : g_bad_pix  $error("PIX_W must be at least 2"); end
   if (LINE_W < 2)       begin : g_bad_line $error("LINE_W must be at least 2"); end
   if (EXP_W < RD_W)     begin : g_bad_cnt  $error("EXP_W must not be below RD_W"); end
   if (FINE_W < 1)       begin : g_bad_fine $error("FINE_W must be at least 1"); end
   if (NUM_W < 1 || HOLD_W < 1) begin : g_bad_num $error("counts need a width"); end

   logic             v_pol, line_on, line_last, pulse;
   logic [PIX_W-1:0] v_on, v_off, v_fine;
   fld_state_e       st_n, st_q;
   logic             clr_q, pol_d;

   shut_line_seq #(
      .PIX_W(PIX_W), .LINE_W(LINE_W), .NUM_W(NUM_W), .HOLD_W(HOLD_W)
   ) u_line (
      .clk(clk), .rst_n(rst_n), .vd(vd), .hd(hd),
      .line_cnt(line_cnt), .gate_line(gate_line),
      .cfg_pol(clr_pol), .cfg_on(clr_tog_on), .cfg_off(clr_tog_off),
      .cfg_fine(clr_fine_pos), .cfg_num(clr_count), .cfg_hold(clr_hold),
      .v_pol(v_pol), .v_on(v_on), .v_off(v_off), .v_fine(v_fine),
      .line_on(line_on), .line_last(line_last)
   );

   shut_pulse_gen #(
      .PIX_W(PIX_W), .FINE_W(FINE_W), .HP_EN(HP_EN)
   ) u_pulse (
      .pix_cnt(pix_cnt), .on_pos(v_on), .off_pos(v_off), .fine_pos(v_fine),
      .line_on(line_on), .line_last(line_last), .pulse(pulse)
   );

   shut_field_fsm #(
      .EXP_W(EXP_W), .RD_W(RD_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .vd(vd),
      .trig_wr(trig_wr), .trig_exp(trig_exp), .trig_rd(trig_rd),
      .exp_fields(exp_fields), .rd_fields(rd_fields),
      .st_n(st_n), .st_q(st_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clr_q <= 1'b0;
         pol_d <= 1'b0;
      end else begin
         clr_q <= v_pol ^ (pulse && (st_n == FS_IDLE));
         pol_d <= v_pol;
      end
   end

   assign sub_clr    = clr_q;
   assign gate_block = (st_q == FS_EXPO);
   assign seq_busy   = (st_q != FS_IDLE);

   AST_CLEAR_HELD_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      seq_busy |-> (sub_clr == pol_d)); // R7
   AST_BLOCK_STARTS_AT_VD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_block) |-> $past(vd)); // R6
   AST_BUSY_STARTS_AT_VD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_busy) |-> $past(vd)); // R10
   AST_BLOCK_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      gate_block |-> seq_busy); // R9
endmodule

// File: tb/sim_shut_expo_ctrl.sv
module sim_shut_expo_ctrl;
   localparam int PIX_W = 13, LINE_W = 12, NUM_W = 12, HOLD_W = 4;
   localparam int EXP_W = 12, RD_W = 3, FINE_W = 4;
   localparam int LINE_LEN = 40, FIELD_LINES = 12, FIELD_LEN = LINE_LEN * FIELD_LINES;
   localparam int FINE_OFF = (1 << PIX_W) - 1;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n = 1'b0, vd = 1'b0, hd = 1'b0;
   logic [PIX_W-1:0]  pix_cnt = '0;
   logic [LINE_W-1:0] line_cnt = '0, gate_line = '0;
   logic              clr_pol = 1'b0;
   logic [PIX_W-1:0]  clr_tog_on = '0, clr_tog_off = '0, clr_fine_pos = '1;
   logic [NUM_W-1:0]  clr_count = '0;
   logic [HOLD_W-1:0] clr_hold = '0;
   logic [EXP_W-1:0]  exp_fields = '0;
   logic [RD_W-1:0]   rd_fields = '0;
   logic              trig_wr = 1'b0, trig_exp = 1'b0, trig_rd = 1'b0;
   logic              sub_clr, gate_block, seq_busy;

   shut_expo_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .vd(vd), .hd(hd), .pix_cnt(pix_cnt),
      .line_cnt(line_cnt), .gate_line(gate_line), .clr_pol(clr_pol),
      .clr_tog_on(clr_tog_on), .clr_tog_off(clr_tog_off),
      .clr_fine_pos(clr_fine_pos), .clr_count(clr_count), .clr_hold(clr_hold),
      .exp_fields(exp_fields), .rd_fields(rd_fields), .trig_wr(trig_wr),
      .trig_exp(trig_exp), .trig_rd(trig_rd), .sub_clr(sub_clr),
      .gate_block(gate_block), .seq_busy(seq_busy)
   );

   int    n_tests = 0, n_fail = 0;
   string cur_req = "R11";
   bit    run_gen = 0, chk_en = 0, done = 0;
   int    gp = LINE_LEN - 1, gl = FIELD_LINES - 1;

   // timing source
   always @(negedge clk) if (run_gen) begin
      gp = (gp == LINE_LEN - 1) ? 0 : gp + 1;
      if (gp == 0) gl = (gl == FIELD_LINES - 1) ? 0 : gl + 1;
      pix_cnt  = PIX_W'(gp);
      line_cnt = LINE_W'(gl);
      hd = (gp == 0);
      vd = (gp == 0) && (gl == 0);
   end

   // behavioural reference
   bit m_loaded = 0;
   int m_rel = 0, m_pol = 0, m_on = 0, m_off = 0, m_fine = FINE_OFF, m_num = 0, m_hold = 0;
   int m_mode = 0, m_left = 0, m_pe = 0, m_pr = 0;
   bit e_clr = 0, e_blk = 0, e_busy = 0;
   int act_pol = 0, fld_act = 0, last_fld_act = 0, blk_cnt = 0, busy_cnt = 0;

   always @(posedge clk) begin
      int old_mode, pe, pr, pix;
      bit act, lastl, inm, inf;
      if (!rst_n) begin
         m_loaded = 0; m_rel = 0; m_pol = 0; m_on = 0; m_off = 0; m_fine = FINE_OFF;
         m_num = 0; m_hold = 0; m_mode = 0; m_left = 0; m_pe = 0; m_pr = 0;
         e_clr = 0; e_blk = 0; e_busy = 0;
      end else begin
         if (sub_clr != act_pol[0]) fld_act++;
         blk_cnt  += int'(gate_block);
         busy_cnt += int'(seq_busy);
         if (vd) begin last_fld_act = fld_act; fld_act = 0; end
         old_mode = m_mode;
         if (hd && int'(line_cnt) == (int'(gate_line) + 1) % (1 << LINE_W)) begin
            m_loaded = 1; m_rel = 0; m_pol = int'(clr_pol); m_on = int'(clr_tog_on);
            m_off = int'(clr_tog_off); m_fine = int'(clr_fine_pos);
            m_num = int'(clr_count); m_hold = int'(clr_hold);
         end else if (vd) m_loaded = 0;
         else if (hd) m_rel++;
         if (vd) begin
            pe = m_pe; pr = m_pr; m_pe = 0; m_pr = 0;
            if (m_mode == 0) begin
               if (pe != 0 && exp_fields != 0) begin m_mode = 1; m_left = int'(exp_fields); end
               else if ((pe != 0 || pr != 0) && rd_fields != 0) begin m_mode = 2; m_left = int'(rd_fields); end
            end else if (m_mode == 1) begin
               m_left--;
               if (m_left == 0) begin
                  if (rd_fields != 0) begin m_mode = 2; m_left = int'(rd_fields); end
                  else m_mode = 0;
               end
            end else begin
               m_left--;
               if (m_left == 0) m_mode = 0;
            end
         end
         if (trig_wr && old_mode == 0 && m_mode == 0) begin
            m_pe |= int'(trig_exp); m_pr |= int'(trig_rd);
         end
         pix   = int'(pix_cnt);
         act   = m_loaded && m_rel >= m_hold && m_rel < m_hold + m_num;
         lastl = act && m_rel == m_hold + m_num - 1;
         inm   = pix >= m_on && pix < m_off;
         inf   = lastl && m_fine != FINE_OFF && pix >= m_fine && pix < m_fine + FINE_W;
         e_clr  = m_pol[0] ^ (m_mode == 0 && act && (inm || inf));
         e_blk  = (m_mode == 1);
         e_busy = (m_mode != 0);
      end
   end

   always @(negedge clk) if (chk_en && !done) begin
      n_tests++;
      if (sub_clr !== e_clr || gate_block !== e_blk || seq_busy !== e_busy) begin
         n_fail++;
         $display("FAIL %s cycle compare: clr/blk/busy=%b%b%b expected %b%b%b",
                  cur_req, sub_clr, gate_block, seq_busy, e_clr, e_blk, e_busy);
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_vd();
      @(negedge clk); #1;
      while (!vd) begin @(negedge clk); #1; end
   endtask

   task automatic field_end();
      wait_vd();
      @(posedge clk); #1;
   endtask

   task automatic trig(input bit e, input bit r);
      @(negedge clk); #1;
      trig_wr = 1'b1; trig_exp = e; trig_rd = r;
      @(negedge clk); #1;
      trig_wr = 1'b0; trig_exp = 1'b0; trig_rd = 1'b0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      #1;
      chk("R11 sub_clr in reset", int'(sub_clr), 0);
      chk("R11 gate_block in reset", int'(gate_block), 0);
      chk("R11 seq_busy in reset", int'(seq_busy), 0);
      gate_line = 2; clr_pol = 0; clr_tog_on = 5; clr_tog_off = 9;
      clr_count = 3; clr_hold = 0; clr_fine_pos = '1; act_pol = 0;
      rst_n = 1'b1; run_gen = 1; chk_en = 1;

      // R1 R2: basic per-line clear pulses
      cur_req = "R1/R2";
      field_end(); field_end(); field_end();
      chk("R1 pulse cycles per field", last_fld_act, 12);
      chk("R5 fine pulse off when all ones", last_fld_act, 12);

      // R3: hold-off lines
      cur_req = "R3"; clr_hold = 2;
      field_end(); field_end();
      chk("R3 pulse cycles with hold-off", last_fld_act, 12);

      // R4: mid-field change after latch line
      cur_req = "R4"; clr_hold = 0;
      field_end();
      repeat (4 * LINE_LEN) @(negedge clk);
      #1; clr_tog_off = 15;
      field_end();
      chk("R4 change after latch ignored", last_fld_act, 12);
      field_end();
      chk("R4 change taken next field", last_fld_act, 30);

      // R5: extra fine pulse on last line, inverted polarity
      cur_req = "R5"; clr_tog_off = 9; clr_pol = 1; clr_fine_pos = 20; act_pol = 1;
      field_end(); field_end();
      chk("R5 fine pulse adds cycles", last_fld_act, 16);

      // R6 R7: exposure then readout
      cur_req = "R6/R7"; clr_pol = 0; clr_fine_pos = '1; act_pol = 0;
      exp_fields = 2; rd_fields = 1;
      field_end();
      blk_cnt = 0; busy_cnt = 0;
      trig(1, 0);
      field_end(); field_end(); field_end(); field_end();
      chk("R7 no pulses in readout field", last_fld_act, 0);
      field_end();
      chk("R7 normal pulses after readout", last_fld_act, 12);
      chk("R6 block cycles", blk_cnt, 2 * FIELD_LEN);
      chk("R7 busy cycles", busy_cnt, 3 * FIELD_LEN);

      // R8: exposure count zero
      cur_req = "R8"; exp_fields = 0; rd_fields = 2;
      blk_cnt = 0; busy_cnt = 0;
      trig(1, 0);
      field_end(); field_end(); field_end(); field_end();
      chk("R8 no block with zero exposure", blk_cnt, 0);
      chk("R8 readout only", busy_cnt, 2 * FIELD_LEN);

      // R9: readout alone
      cur_req = "R9"; exp_fields = 3;
      blk_cnt = 0; busy_cnt = 0;
      trig(0, 1);
      field_end(); field_end(); field_end(); field_end();
      chk("R9 readout alone no block", blk_cnt, 0);
      chk("R9 readout alone busy", busy_cnt, 2 * FIELD_LEN);

      // R10: trigger while running, trigger in field-start cycle
      cur_req = "R10"; exp_fields = 1; rd_fields = 1;
      blk_cnt = 0; busy_cnt = 0;
      trig(1, 0);
      field_end();
      trig(1, 1);
      field_end(); field_end(); field_end(); field_end();
      chk("R10 busy trigger dropped", busy_cnt, 2 * FIELD_LEN);
      chk("R10 single exposure field", blk_cnt, FIELD_LEN);
      wait_vd();
      trig_wr = 1'b1; trig_rd = 1'b1;
      @(negedge clk); #1;
      trig_wr = 1'b0; trig_rd = 1'b0;
      chk("R10 trigger in VD cycle waits", int'(seq_busy), 0);
      field_end();
      chk("R10 pending trigger taken", int'(seq_busy), 1);
      field_end();
      chk("R10 busy ends after readout", int'(seq_busy), 0);

      done = 1;
      summary();
      $finish;
   end
endmodule